// File: doc/BRIEF.md
# Linked Descriptor DMA Engine

This block is a scatter-gather DMA engine. It follows a chain of 64-bit descriptors held in memory and moves data words between that memory and a card data FIFO. Software writes the table, then pulses `start` with the table base, the total byte count it expects to move and the direction. The engine reads each descriptor as two 32-bit words. Depending on the two-bit action code, it then moves a buffer, skips the line, or jumps to another table location. It keeps going until a line carrying the end flag completes or an error halts it.

Descriptors and data share one word-wide memory port. The port uses a request/acknowledge handshake with one access outstanding. The FIFO side has two valid/ready streams, one outbound (memory to card) and one inbound (card to memory). A word moves on a stream in a cycle where both valid and ready are high. While `tx_valid` is high and `tx_ready` is low, the engine holds `tx_valid` and keeps `tx_data` unchanged. When the engine cannot accept inbound data, it drops `rx_ready`, and the source must hold its word.

When a descriptor with the interrupt flag completes, `irq` pulses. Errors stay latched until the next start. `err_state` then records which engine phase detected the problem.

Top module: `dmaw_engine`

## Requirements
- R1: After reset, `busy`, `irq`, `err_desc`, `err_len`, `mem_req`, `tx_valid` and `rx_ready` are 0 and `err_state` is 0.
- R2: A descriptor at pointer P is fetched as a word read at P followed by one at P+4. The first word holds the attribute: bit 0 valid, bit 1 end, bit 2 interrupt, bits 5:4 action code, bit 3 and bits 15:6 reserved. It also holds the byte length in bits 31:16. The second word is the address.
- R3: For action code 2 (transfer) with `to_card`=1, the engine reads length/4 words from ascending addresses starting at the descriptor address. It presents them in order on the outbound stream, holding valid and data stable until ready.
- R4: For a transfer with `to_card`=0, each word accepted on the inbound stream is written to ascending addresses starting at the descriptor address.
- R5: Action code 0 (nop) and code 1 (reserved) move no data, and the next descriptor is fetched from P+8. A transfer line also advances the pointer to P+8.
- R6: Action code 3 (link) moves no data and makes the next fetch come from the line's address field.
- R7: After a line with the end flag completes its action, the engine stops and `busy` returns to 0.
- R8: Completing a line whose interrupt flag is set produces exactly one single-cycle `irq` pulse.
- R9: A first descriptor word with the valid bit clear sets `err_desc` and sets `err_state` to 1 (fetch). The engine then stops without moving data.
- R10: A transfer line whose address or length is not a multiple of 4 sets `err_desc` with `err_state` 2 (address change) and moves no data. A line with a nonzero reserved bit does the same.
- R11: When an end line completes and the total bytes moved differ from `xfer_bytes`, `err_len` is set. `err_state` is 3 (transfer) if that line was a transfer, and 2 otherwise.
- R12: A `start` pulse while `busy` is ignored. A new start clears `err_desc`, `err_len` and `err_state`.
- R13: Every memory request is word aligned. It holds `mem_req` and `mem_addr` steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin walking a table |
| table_base | input | ADDR_W | Byte address of the first descriptor |
| xfer_bytes | input | SIZE_W | Total bytes the chain is expected to move |
| to_card | input | 1 | 1: memory to FIFO, 0: FIFO to memory |
| busy | output | 1 | Engine is walking a chain |
| irq | output | 1 | One-cycle pulse when an interrupt-flagged line completes |
| err_desc | output | 1 | Latched descriptor error |
| err_len | output | 1 | Latched length mismatch |
| err_state | output | 2 | Phase of the latched error: 0 stop, 1 fetch, 2 address change, 3 transfer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Outbound word valid |
| tx_ready | input | 1 | FIFO accepts outbound word |
| tx_data | output | 32 | Outbound word |
| rx_valid | input | 1 | Inbound word valid |
| rx_ready | output | 1 | Engine accepts inbound word |
| rx_data | input | 32 | Inbound word |

## Verification
A vector table drives single-line chains through the engine: transfers with and without the end flag, nop and reserved lines, an invalid line, misaligned address and length, a zero-length transfer, and programmed sizes that match or miss. Together these separate the four action codes and tell the three error origins apart. Directed runs cover a link jump, which shows whether the pointer is replaced or merely advanced. They also cover an inbound transfer checked word by word in memory, and a second start issued mid-run, which shows whether the engine restarts. The outbound FIFO applies periodic back-pressure so that the check of word order also shows that each word is held, not dropped or repeated.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  localparam int WORD_W = 32;
  localparam int ATTR_VALID = 0;
  localparam int ATTR_END   = 1;
  localparam int ATTR_INT   = 2;
  localparam int ATTR_ACT_LO = 4;

  typedef enum logic [1:0] {
    PH_STOP   = 2'd0,
    PH_FETCH  = 2'd1,
    PH_CHADDR = 2'd2,
    PH_MOVE   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ACT_NOP  = 2'd0,
    ACT_RSV  = 2'd1,
    ACT_XFER = 2'd2,
    ACT_LINK = 2'd3
  } act_e;

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] len;
    logic        valid;
    logic        last;
    logic        intr;
    act_e        act;
    logic        aligned;
    logic        rsv_clean;
  } desc_t;
endpackage

// File: rtl/dmaw_decode.sv
module dmaw_decode
  import dmaw_pkg::*;
(
  input  logic [63:0] raw,
  output desc_t       dsc
);
  always_comb begin
    dsc.addr      = raw[63:32];
    dsc.len       = raw[31:16];
    dsc.valid     = raw[ATTR_VALID];
    dsc.last      = raw[ATTR_END];
    dsc.intr      = raw[ATTR_INT];
    dsc.act       = act_e'(raw[ATTR_ACT_LO +: 2]);
    dsc.aligned   = (raw[33:32] == 2'b00) && (raw[17:16] == 2'b00);
    dsc.rsv_clean = (raw[15:6] == 10'd0) && !raw[3];
  end
endmodule

// File: rtl/dmaw_mover.sv
module dmaw_mover
  import dmaw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              to_card,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  nwords,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [WORD_W-1:0] rx_data
);
  typedef enum logic [2:0] {MV_IDLE, MV_RD, MV_PUSH, MV_POP, MV_WR} mv_e;

  mv_e               st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [WORD_W-1:0] hold_q;
  logic              last_word;

  assign last_word = (left_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MV_IDLE;
      addr_q <= '0;
      left_q <= '0;
      hold_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        MV_IDLE: if (go) begin
          addr_q <= base;
          left_q <= nwords;
          if (nwords == '0) done <= 1'b1;
          else st_q <= to_card ? MV_RD : MV_POP;
        end
        MV_RD: if (mem_ack) begin
          hold_q <= mem_rdata;
          st_q   <= MV_PUSH;
        end
        MV_PUSH: if (tx_ready) begin
          addr_q <= addr_q + ADDR_W'(4);
          left_q <= left_q - CNT_W'(1);
          if (last_word) begin
            done <= 1'b1;
            st_q <= MV_IDLE;
          end else st_q <= MV_RD;
        end
        MV_POP: if (rx_valid) begin
          hold_q <= rx_data;
          st_q   <= MV_WR;
        end
        MV_WR: if (mem_ack) begin
          addr_q <= addr_q + ADDR_W'(4);
          left_q <= left_q - CNT_W'(1);
          if (last_word) begin
            done <= 1'b1;
            st_q <= MV_IDLE;
          end else st_q <= MV_POP;
        end
        default: st_q <= MV_IDLE;
      endcase
    end
  end

  assign mem_req   = (st_q == MV_RD) || (st_q == MV_WR);
  assign mem_we    = (st_q == MV_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = hold_q;
  assign tx_valid  = (st_q == MV_PUSH);
  assign tx_data   = hold_q;
  assign rx_ready  = (st_q == MV_POP);

  // R3: an offered outbound word stays offered and unchanged until taken
  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R13: a pending data access keeps its address until acknowledged
  assert_mem_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

// File: rtl/dmaw_engine.sv
module dmaw_engine
  import dmaw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] table_base,
  input  logic [SIZE_W-1:0] xfer_bytes,
  input  logic              to_card,
  output logic              busy,
  output logic              irq,
  output logic              err_desc,
  output logic              err_len,
  output logic [1:0]        err_state,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [31:0]       rx_data
);
  localparam int CNT_W = LEN_W - 2;
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(8);

  phase_e            ph_q;
  logic              half_q;
  logic              dir_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [31:0]       lo_q, hi_q;
  logic [SIZE_W-1:0] size_q, moved_q, moved_nx;
  desc_t             dsc;
  phase_e            est_q;

  logic              mv_go, mv_done, mv_req, mv_we;
  logic [ADDR_W-1:0] mv_addr;

  dmaw_decode u_dec (.raw({hi_q, lo_q}), .dsc(dsc));

  assign mv_go = (ph_q == PH_CHADDR) && (dsc.act == ACT_XFER) && dsc.aligned && dsc.rsv_clean;
  assign moved_nx = moved_q + SIZE_W'(dsc.len);

  dmaw_mover #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_mv (
    .clk(clk), .rst_n(rst_n), .go(mv_go), .to_card(dir_q),
    .base(dsc.addr[ADDR_W-1:0]), .nwords(dsc.len[LEN_W-1:2]), .done(mv_done),
    .mem_req(mv_req), .mem_we(mv_we), .mem_addr(mv_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  always_comb begin
    if (ph_q == PH_FETCH) begin
      mem_req  = 1'b1;
      mem_we   = 1'b0;
      mem_addr = ptr_q + (half_q ? ADDR_W'(4) : ADDR_W'(0));
    end else begin
      mem_req  = mv_req;
      mem_we   = mv_we;
      mem_addr = mv_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_STOP;
      half_q   <= 1'b0;
      dir_q    <= 1'b0;
      ptr_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      size_q   <= '0;
      moved_q  <= '0;
      irq      <= 1'b0;
      err_desc <= 1'b0;
      err_len  <= 1'b0;
      est_q    <= PH_STOP;
    end else begin
      irq <= 1'b0;
      unique case (ph_q)
        PH_STOP: if (start) begin
          ptr_q    <= table_base;
          size_q   <= xfer_bytes;
          dir_q    <= to_card;
          moved_q  <= '0;
          half_q   <= 1'b0;
          err_desc <= 1'b0;
          err_len  <= 1'b0;
          est_q    <= PH_STOP;
          ph_q     <= PH_FETCH;
        end
        PH_FETCH: if (mem_ack) begin
          if (!half_q) begin
            if (!mem_rdata[ATTR_VALID]) begin
              err_desc <= 1'b1;
              est_q    <= PH_FETCH;
              ph_q     <= PH_STOP;
            end else begin
              lo_q   <= mem_rdata;
              half_q <= 1'b1;
            end
          end else begin
            hi_q   <= mem_rdata;
            half_q <= 1'b0;
            ph_q   <= PH_CHADDR;
          end
        end
        PH_CHADDR: begin
          if (!dsc.rsv_clean || (dsc.act == ACT_XFER && !dsc.aligned)) begin
            err_desc <= 1'b1;
            est_q    <= PH_CHADDR;
            ph_q     <= PH_STOP;
          end else if (dsc.act == ACT_XFER) begin
            ph_q <= PH_MOVE;
          end else begin
            ptr_q <= (dsc.act == ACT_LINK) ? dsc.addr[ADDR_W-1:0] : ptr_q + STRIDE;
            irq   <= dsc.intr;
            if (dsc.last) begin
              ph_q <= PH_STOP;
              if (moved_q != size_q) begin
                err_len <= 1'b1;
                est_q   <= PH_CHADDR;
              end
            end else ph_q <= PH_FETCH;
          end
        end
        PH_MOVE: if (mv_done) begin
          moved_q <= moved_nx;
          ptr_q   <= ptr_q + STRIDE;
          irq     <= dsc.intr;
          if (dsc.last) begin
            ph_q <= PH_STOP;
            if (moved_nx != size_q) begin
              err_len <= 1'b1;
              est_q   <= PH_MOVE;
            end
          end else ph_q <= PH_FETCH;
        end
        default: ph_q <= PH_STOP;
      endcase
    end
  end

  assign busy      = (ph_q != PH_STOP);
  assign err_state = est_q;

  // R8: an interrupt is a lone single-cycle pulse
  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R9: a latched error means the engine has stopped
  assert_err_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_desc || err_len) |-> !busy);

  // R12: a run begins with the error flags cleared
  assert_start_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !err_desc && !err_len && err_state == 2'd0);

  // R13: all accesses are word aligned
  assert_word_aligned_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  // R13: a pending fetch keeps its address until acknowledged
  assert_fetch_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
endmodule

// File: tb/dmaw_engine_bench.sv
module dmaw_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] table_base = '0;
  logic [23:0] xfer_bytes = '0;
  logic        to_card = 1'b1;
  logic        busy, irq, err_desc, err_len;
  logic [1:0]  err_state;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, rx_valid, rx_ready;
  logic [31:0] tx_data, rx_data;

  always #5 clk = ~clk;

  dmaw_engine u_dmaw_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .table_base(table_base),
    .xfer_bytes(xfer_bytes), .to_card(to_card), .busy(busy), .irq(irq),
    .err_desc(err_desc), .err_len(err_len), .err_state(err_state),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  // memory model, poke port, FIFO models and monitors
  logic [31:0] mem [256];
  logic        pk_en = 1'b0;
  logic [7:0]  pk_idx = '0;
  logic [31:0] pk_dat = '0;
  logic        clr = 1'b0;
  logic [31:0] cap [64];
  int          ncap, nirq, rx_k, nbad, cyc;

  assign tx_ready = (cyc[1:0] != 2'b01);
  assign rx_valid = cyc[0];
  assign rx_data  = 32'h5000_0000 + rx_k;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pk_en) mem[pk_idx] <= pk_dat;
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end else mem_ack <= 1'b0;
    if (clr) begin
      ncap <= 0; nirq <= 0; rx_k <= 0;
    end else begin
      if (tx_valid && tx_ready) begin cap[ncap[5:0]] <= tx_data; ncap <= ncap + 1; end
      if (irq) nirq <= nirq + 1;
      if (rx_valid && rx_ready) rx_k <= rx_k + 1;
    end
    if (rst_n && mem_req && mem_addr[1:0] != 2'b00) nbad <= nbad + 1;
  end

  int n_run = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    pk_en = 1'b1; pk_idx = a[9:2]; pk_dat = d;
    @(negedge clk);
    pk_en = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [5:0] attr,
                          input logic [15:0] len, input logic [31:0] addr);
    poke(at, {len, 10'd0, attr});
    poke(at + 4, addr);
  endtask

  task automatic clear_mon();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int c = 0;
    while (busy && c < 4000) begin @(negedge clk); c++; end
    if (busy) chk({tag, " timeout"}, 32'd1, 32'd0);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic [31:0] base, input logic [23:0] size, input logic dir, input string tag);
    clear_mon();
    table_base = base; xfer_bytes = size; to_card = dir; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle(tag);
  endtask

  typedef struct packed {
    logic [5:0]  attr;
    logic [15:0] len;
    logic [15:0] addr;
    logic [15:0] size;
    logic        e_desc;
    logic        e_len;
    logic [1:0]  e_st;
    logic [1:0]  e_irq;
    logic [7:0]  e_words;
  } vec_t;

  // attr: bit0 valid, bit1 end, bit2 interrupt, bits5:4 action (0 nop,1 rsv,2 xfer,3 link)
  localparam vec_t VECS [10] = '{
    '{6'h27, 16'd16, 16'h0200, 16'd16, 1'b0, 1'b0, 2'd0, 2'd1, 8'd4}, // R3 R8 xfer end int
    '{6'h23, 16'd16, 16'h0200, 16'd20, 1'b0, 1'b1, 2'd3, 2'd0, 8'd4}, // R11 mismatch on xfer
    '{6'h07, 16'd0,  16'h0000, 16'd0,  1'b0, 1'b0, 2'd0, 2'd1, 8'd0}, // R5 nop end int
    '{6'h11, 16'd0,  16'h0000, 16'd0,  1'b0, 1'b0, 2'd0, 2'd0, 8'd0}, // R5 reserved, then terminator
    '{6'h22, 16'd16, 16'h0200, 16'd16, 1'b1, 1'b0, 2'd1, 2'd0, 8'd0}, // R9 valid clear
    '{6'h23, 16'd16, 16'h0202, 16'd16, 1'b1, 1'b0, 2'd2, 2'd0, 8'd0}, // R10 bad address
    '{6'h23, 16'd6,  16'h0200, 16'd6,  1'b1, 1'b0, 2'd2, 2'd0, 8'd0}, // R10 bad length
    '{6'h21, 16'd8,  16'h0200, 16'd8,  1'b0, 1'b0, 2'd0, 2'd0, 8'd2}, // R5 R2 xfer then terminator
    '{6'h03, 16'd0,  16'h0000, 16'd4,  1'b0, 1'b1, 2'd2, 2'd0, 8'd0}, // R11 mismatch on nop
    '{6'h23, 16'd0,  16'h0200, 16'd0,  1'b0, 1'b0, 2'd0, 2'd0, 8'd0}  // R3 zero-length xfer
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    ncap = 0; nirq = 0; rx_k = 0; nbad = 0; cyc = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 errors", {28'd0, err_desc, err_len, err_state}, 32'd0);
    chk("R1 ports", {29'd0, mem_req, tx_valid, rx_ready}, 32'd0);
    rst_n = 1'b1;

    for (int j = 0; j < 32; j++) poke(32'h200 + 32'(j) * 4, 32'hA000_0000 + 32'(j));
    put_desc(32'h008, 6'h03, 16'd0, 32'd0); // terminator: nop + end

    for (int v = 0; v < 10; v++) begin
      put_desc(32'h000, VECS[v].attr, VECS[v].len, {16'd0, VECS[v].addr});
      run(32'h0, {8'd0, VECS[v].size}, 1'b1, $sformatf("vec%0d", v));
      chk($sformatf("R7 vec%0d stopped", v), {31'd0, busy}, 32'd0);
      chk($sformatf("R9 R10 vec%0d err_desc", v), {31'd0, err_desc}, {31'd0, VECS[v].e_desc});
      chk($sformatf("R11 vec%0d err_len", v), {31'd0, err_len}, {31'd0, VECS[v].e_len});
      chk($sformatf("R11 vec%0d err_state", v), {30'd0, err_state}, {30'd0, VECS[v].e_st});
      chk($sformatf("R8 vec%0d irq count", v), 32'(nirq), {30'd0, VECS[v].e_irq});
      chk($sformatf("R3 vec%0d words", v), 32'(ncap), {24'd0, VECS[v].e_words});
      for (int k = 0; k < int'(VECS[v].e_words); k++)
        chk($sformatf("R3 vec%0d word%0d", v, k), cap[k], 32'hA000_0000 + 32'(k));
    end

    // R6 link jumps to its address field
    put_desc(32'h000, 6'h31, 16'd0, 32'h100);
    put_desc(32'h100, 6'h27, 16'd8, 32'h208);
    run(32'h0, 24'd8, 1'b1, "link");
    chk("R6 link words", 32'(ncap), 32'd2);
    chk("R6 link first word", cap[0], 32'hA000_0002);
    chk("R6 link second word", cap[1], 32'hA000_0003);
    chk("R6 link no error", {30'd0, err_desc, err_len}, 32'd0);
    chk("R8 link irq", 32'(nirq), 32'd1);

    // R4 inbound transfer into memory
    put_desc(32'h000, 6'h23, 16'd12, 32'h300);
    run(32'h0, 24'd12, 1'b0, "rx");
    for (int k = 0; k < 3; k++)
      chk($sformatf("R4 mem word%0d", k), mem[192 + k], 32'h5000_0000 + 32'(k));
    chk("R4 no outbound", 32'(ncap), 32'd0);
    chk("R4 no error", {30'd0, err_desc, err_len}, 32'd0);

    // set an error, then R12: restart clears it, second start mid-run ignored
    put_desc(32'h000, 6'h22, 16'd0, 32'd0);
    run(32'h0, 24'd0, 1'b1, "pre-err");
    chk("R9 error set", {31'd0, err_desc}, 32'd1);
    put_desc(32'h000, 6'h23, 16'd16, 32'h200);
    put_desc(32'h100, 6'h23, 16'd4, 32'h27C);
    clear_mon();
    table_base = 32'h0; xfer_bytes = 24'd16; to_card = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    table_base = 32'h100; xfer_bytes = 24'd4; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_idle("restart");
    chk("R12 words from first run", 32'(ncap), 32'd4);
    chk("R12 first word", cap[0], 32'hA000_0000);
    chk("R12 errors cleared", {28'd0, err_desc, err_len, err_state}, 32'd0);

    chk("R13 aligned requests", 32'(nbad), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule